// File: doc/BRIEF.md
# Multiply Occupancy and Completion Tracker

This block sits beside the issue logic of an integer core whose multiplier has no internal pipelining and shares issue pipe 0. It performs no arithmetic. It counts cycles for each accepted multiply and tells the issue logic three things:

- when the multiplier can take new work;
- in which single cycle pipe 0 must stay empty because the multiplier writes back through it;
- in which cycle the product appears.

The multiplier cannot take operands from the execution bypass network. The block therefore keeps a two-cycle history of the destination registers written by both issue pipes. It compares each multiply source register against that history and adds the matching penalty to the completion time. For every accepted multiply it reports the resulting latency in the following cycle.

A two-state machine controls occupancy:

- ST_IDLE moves to ST_BUSY on the accept transition, which is an issue request while idle.
- ST_BUSY counts down and takes the expiry transition back to ST_IDLE when its counter reaches zero.
- ST_BUSY holds in every other cycle.

Future events are kept in shift-register timelines, one each for the pipe 0 block, the result-ready pulse and the dependent-multiply pulse. Because they are timelines, events from overlapping multiplies never overwrite each other.

Top module: `mul_hazard_tracker`

## Requirements
- R1: While reset is asserted and after it is released, mul_busy, pipe0_blocked, result_ready, chain_ready and lat_valid are low until a multiply is accepted.
- R2: The size code selects the base latency: 2'b00 (32-bit) gives 8 cycles, 2'b01 (64-bit) gives 12 cycles, and 2'b10 or 2'b11 (upper half of a 64-bit product) give 14 cycles. result_ready is high in cycle t+latency for a multiply accepted in cycle t.
- R3: An issue request in cycle t is accepted when mul_busy is low. mul_busy is then high for cycles t+1 to t+3 (32-bit) or t+1 to t+7 (other sizes), and a request in the first cycle it is low again is accepted.
- R4: An issue request made while mul_busy is high is ignored: no lat_valid, no pipe0_blocked, no result_ready, and no change to the busy window.
- R5: pipe0_blocked is high for exactly one cycle per accepted multiply, at t+5 (32-bit), t+9 (64-bit) or t+11 (upper half), whatever the operand penalty.
- R6: A source register matching a destination written by either pipe in cycle t-1 adds 2 cycles to the latency.
- R7: A source register matching a destination written in cycle t-2, and no destination written in t-1, adds 1 cycle. With two sources the larger penalty applies, and the penalties do not add.
- R8: chain_ready is high exactly one cycle after each result_ready cycle, giving the earliest cycle in which a dependent multiply may use the product (9, 13 or 15 cycles with no penalty).
- R9: lat_valid is high in cycle t+1 for each accepted multiply, and lat_cycles then holds the effective latency.
- R10: If the completion cycle of a new multiply equals the pending completion cycle of an earlier one, the new completion moves one cycle later, and lat_cycles reports the moved value.
- R11: result_ready pulses exactly once for each accepted multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Multiply issue request this cycle |
| issue_size | input | 2 | Size code: 00 32-bit, 01 64-bit, 1x upper half |
| src_a | input | REG_W | First source register of the multiply |
| src_b | input | REG_W | Second source register of the multiply |
| p0_wr_valid | input | 1 | Pipe 0 issued a register-writing instruction this cycle |
| p0_wr_reg | input | REG_W | Destination register of that pipe 0 instruction |
| p1_wr_valid | input | 1 | Pipe 1 issued a register-writing instruction this cycle |
| p1_wr_reg | input | REG_W | Destination register of that pipe 1 instruction |
| mul_busy | output | 1 | Multiplier occupied; new requests are ignored |
| pipe0_blocked | output | 1 | Pipe 0 must not issue this cycle |
| result_ready | output | 1 | A product completes this cycle |
| chain_ready | output | 1 | A dependent multiply may use the product from this cycle |
| lat_valid | output | 1 | lat_cycles holds the latency of the multiply accepted last cycle |
| lat_cycles | output | 5 | Effective latency in cycles |

## Verification
The bench targets the edges of the busy window. A second request in the last busy cycle must be dropped, and one in the first free cycle must be taken. A design off by one would either drop the second multiply or start a second completion. The bench checks that a producer one cycle back outranks the same register two cycles back, and that two matching sources do not add their penalties. An encoder with the wrong priority or a summing penalty would report 11 or 12 where 10 is expected. The completion collision of an upper-half multiply followed eight cycles later by a 32-bit one is driven directly. If the slip is missing, the two pulses merge into one and R11 fails. The bench also applies reset in the middle of a multiply, which exposes timelines that reset does not clear.

// File: rtl/mh_pkg.sv
package mh_pkg;

    typedef enum logic [1:0] {
        SZ_W32  = 2'b00,
        SZ_W64  = 2'b01,
        SZ_HI64 = 2'b10,
        SZ_HIX  = 2'b11
    } mul_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } occ_state_e;

    localparam int LAT_W32   = 8;
    localparam int LAT_W64   = 12;
    localparam int LAT_HI    = 14;
    localparam int OCC_W32   = 4;
    localparam int OCC_W64   = 8;
    localparam int SLOT_W32  = 5;
    localparam int SLOT_W64  = 9;
    localparam int SLOT_HI   = 11;
    localparam int PEN_NEAR  = 2;
    localparam int PEN_FAR   = 1;
    localparam int MAX_LAT   = LAT_HI;
    localparam int MAX_PEN   = PEN_NEAR;
    // one extra slot for a slipped completion, one for the chain pulse
    localparam int LINE_W    = MAX_LAT + MAX_PEN + 2;
    localparam int IDX_W     = $clog2(LINE_W);
    localparam int LATV_W    = $clog2(LINE_W + 1);
    localparam int OCC_CNT_W = $clog2(OCC_W64);

    typedef logic [LATV_W-1:0] lat_t;

    function automatic lat_t base_lat(input logic [1:0] sz);
        unique case (sz)
            SZ_W32:  return lat_t'(LAT_W32);
            SZ_W64:  return lat_t'(LAT_W64);
            default: return lat_t'(LAT_HI);
        endcase
    endfunction

    function automatic lat_t occ_len(input logic [1:0] sz);
        return (sz == SZ_W32) ? lat_t'(OCC_W32) : lat_t'(OCC_W64);
    endfunction

    function automatic lat_t late_slot(input logic [1:0] sz);
        unique case (sz)
            SZ_W32:  return lat_t'(SLOT_W32);
            SZ_W64:  return lat_t'(SLOT_W64);
            default: return lat_t'(SLOT_HI);
        endcase
    endfunction

endpackage

// File: rtl/mh_operand_age.sv
module mh_operand_age #(
    parameter int REG_W = 5,
    parameter int NPIPE = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPIPE-1:0]             wr_valid,
    input  logic [NPIPE-1:0][REG_W-1:0]  wr_reg,
    input  logic [REG_W-1:0]             src_a,
    input  logic [REG_W-1:0]             src_b,
    output logic [1:0]                   penalty
);

    logic [NPIPE-1:0]            near_v, far_v;
    logic [NPIPE-1:0][REG_W-1:0] near_r, far_r;
    logic [NPIPE-1:0]            na_hit, nb_hit, fa_hit, fb_hit;
    logic [1:0]                  pen_a, pen_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            near_v <= '0;
            far_v  <= '0;
            near_r <= '0;
            far_r  <= '0;
        end else begin
            near_v <= wr_valid;
            near_r <= wr_reg;
            far_v  <= near_v;
            far_r  <= near_r;
        end
    end

    for (genvar p = 0; p < NPIPE; p++) begin : g_cmp
        assign na_hit[p] = near_v[p] && (near_r[p] == src_a);
        assign nb_hit[p] = near_v[p] && (near_r[p] == src_b);
        assign fa_hit[p] = far_v[p]  && (far_r[p]  == src_a);
        assign fb_hit[p] = far_v[p]  && (far_r[p]  == src_b);
    end

    always_comb begin
        pen_a = (|na_hit) ? 2'(mh_pkg::PEN_NEAR) : (|fa_hit) ? 2'(mh_pkg::PEN_FAR) : 2'd0;
        pen_b = (|nb_hit) ? 2'(mh_pkg::PEN_NEAR) : (|fb_hit) ? 2'(mh_pkg::PEN_FAR) : 2'd0;
        penalty = (pen_a > pen_b) ? pen_a : pen_b;
    end

endmodule

// File: rtl/mh_busy_fsm.sv
module mh_busy_fsm
    import mh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] size,
    output logic       busy
);

    occ_state_e           state, state_nxt;
    logic [OCC_CNT_W-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nxt = ST_BUSY;
                    cnt_nxt   = OCC_CNT_W'(occ_len(size) - lat_t'(2));
                end
            end
            ST_BUSY: begin
                if (cnt == '0) state_nxt = ST_IDLE;
                else           cnt_nxt   = cnt - 1'b1;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy = (state == ST_BUSY);
    end

endmodule

// File: rtl/mh_event_line.sv
module mh_event_line #(
    parameter int W  = 18,
    parameter int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    output logic          fire,
    output logic [W-1:0]  ahead
);

    logic [W-1:0] line, line_nxt;

    assign ahead = line >> 1;
    assign fire  = line[0];

    always_comb begin
        line_nxt = ahead;
        if (set_en) line_nxt[set_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line <= '0;
        else        line <= line_nxt;
    end

endmodule

// File: rtl/mul_hazard_tracker.sv
module mul_hazard_tracker
    import mh_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [1:0]       issue_size,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic             p0_wr_valid,
    input  logic [REG_W-1:0] p0_wr_reg,
    input  logic             p1_wr_valid,
    input  logic [REG_W-1:0] p1_wr_reg,
    output logic             mul_busy,
    output logic             pipe0_blocked,
    output logic             result_ready,
    output logic             chain_ready,
    output logic             lat_valid,
    output logic [4:0]       lat_cycles
);

    localparam int NPIPE = 2;

    logic              accept;
    logic [1:0]        penalty;
    lat_t              eff_lat, fin_lat;
    logic              slip;
    logic [LINE_W-1:0] rdy_ahead, blk_ahead, chn_ahead;
    logic [NPIPE-1:0]             wr_v;
    logic [NPIPE-1:0][REG_W-1:0]  wr_r;

    assign wr_v = {p1_wr_valid, p0_wr_valid};
    assign wr_r = {p1_wr_reg, p0_wr_reg};

    assign accept = issue_valid && !mul_busy;

    mh_operand_age #(.REG_W(REG_W), .NPIPE(NPIPE)) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_v),
        .wr_reg   (wr_r),
        .src_a    (src_a),
        .src_b    (src_b),
        .penalty  (penalty)
    );

    mh_busy_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .size  (issue_size),
        .busy  (mul_busy)
    );

    always_comb begin
        eff_lat = base_lat(issue_size) + lat_t'(penalty);
        slip    = rdy_ahead[IDX_W'(eff_lat - lat_t'(1))];
        fin_lat = eff_lat + lat_t'(slip);
    end

    mh_event_line #(.W(LINE_W), .IW(IDX_W)) u_blk_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (accept),
        .set_idx (IDX_W'(late_slot(issue_size) - lat_t'(1))),
        .fire    (pipe0_blocked),
        .ahead   (blk_ahead)
    );

    mh_event_line #(.W(LINE_W), .IW(IDX_W)) u_rdy_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (accept),
        .set_idx (IDX_W'(fin_lat - lat_t'(1))),
        .fire    (result_ready),
        .ahead   (rdy_ahead)
    );

    mh_event_line #(.W(LINE_W), .IW(IDX_W)) u_chn_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (accept),
        .set_idx (IDX_W'(fin_lat)),
        .fire    (chain_ready),
        .ahead   (chn_ahead)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_valid  <= 1'b0;
            lat_cycles <= '0;
        end else begin
            lat_valid  <= accept;
            if (accept) lat_cycles <= 5'(fin_lat);
        end
    end

    logic unused_ok;
    assign unused_ok = ^{blk_ahead, chn_ahead};

endmodule

// File: rtl/mh_checker.sv
module mh_checker #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue_valid,
    input logic [1:0]       issue_size,
    input logic [REG_W-1:0] src_a,
    input logic [REG_W-1:0] src_b,
    input logic             p0_wr_valid,
    input logic [REG_W-1:0] p0_wr_reg,
    input logic             p1_wr_valid,
    input logic [REG_W-1:0] p1_wr_reg,
    input logic             mul_busy,
    input logic             pipe0_blocked,
    input logic             result_ready,
    input logic             chain_ready,
    input logic             lat_valid,
    input logic [4:0]       lat_cycles
);

    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && mul_busy) |=> !lat_valid); // R4

    AST_ACCEPT_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !mul_busy) |=> (mul_busy && lat_valid)); // R3

    AST_LAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        lat_valid |-> (lat_cycles >= 5'd8 && lat_cycles <= 5'd17)); // R9

    AST_CHAIN_FOLLOWS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        result_ready |=> chain_ready); // R8

    AST_CHAIN_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        chain_ready |-> $past(result_ready)); // R8

endmodule

bind mul_hazard_tracker mh_checker #(.REG_W(REG_W)) u_chk (.*);

// File: tb/sim_mul_hazard_tracker.sv
`timescale 1ns/1ps
module sim_mul_hazard_tracker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_valid = 1'b0;
    logic [1:0] issue_size = 2'd0;
    logic [4:0] src_a = 5'd0, src_b = 5'd0;
    logic       p0_wr_valid = 1'b0, p1_wr_valid = 1'b0;
    logic [4:0] p0_wr_reg = 5'd0, p1_wr_reg = 5'd0;
    logic       mul_busy, pipe0_blocked, result_ready, chain_ready, lat_valid;
    logic [4:0] lat_cycles;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mul_hazard_tracker #(.REG_W(5)) u0 (.*);

    typedef struct packed {
        logic [1:0] sz;
        logic [4:0] a;
        logic [4:0] b;
        logic       p1v;
        logic [4:0] p1;
        logic       p2v;
        logic [4:0] p2;
        logic [4:0] lat;
    } vec_t;

    // p1: producer one cycle before issue (pipe 0), p2: two cycles before (pipe 1)
    localparam vec_t VEC [11] = '{
        '{2'd0, 5'd3,  5'd4,  1'b0, 5'd0,  1'b0, 5'd0,  5'd8},
        '{2'd1, 5'd3,  5'd4,  1'b0, 5'd0,  1'b0, 5'd0,  5'd12},
        '{2'd2, 5'd3,  5'd4,  1'b0, 5'd0,  1'b0, 5'd0,  5'd14},
        '{2'd0, 5'd5,  5'd4,  1'b1, 5'd5,  1'b0, 5'd0,  5'd10},
        '{2'd0, 5'd5,  5'd4,  1'b0, 5'd0,  1'b1, 5'd5,  5'd9},
        '{2'd1, 5'd6,  5'd7,  1'b1, 5'd7,  1'b1, 5'd6,  5'd14},
        '{2'd2, 5'd1,  5'd9,  1'b0, 5'd0,  1'b1, 5'd9,  5'd15},
        '{2'd1, 5'd2,  5'd2,  1'b1, 5'd8,  1'b1, 5'd10, 5'd12},
        '{2'd2, 5'd11, 5'd1,  1'b1, 5'd11, 1'b0, 5'd0,  5'd16},
        '{2'd0, 5'd12, 5'd12, 1'b1, 5'd12, 1'b1, 5'd12, 5'd10},
        '{2'd3, 5'd3,  5'd4,  1'b0, 5'd0,  1'b0, 5'd0,  5'd14}
    };

    logic [31:0] r_hit, b_hit, c_hit, v_hit, u_hit;
    int          lat_at [32];

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int first_set(input logic [31:0] v);
        for (int i = 1; i < 32; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic int exp_occ(input logic [1:0] sz);
        return (sz == 2'd0) ? 3 : 7;
    endfunction

    function automatic int exp_slot(input logic [1:0] sz);
        return (sz == 2'd0) ? 5 : (sz == 2'd1) ? 9 : 11;
    endfunction

    // Called in cycle t with the issue already driven; samples cycles t+1..t+n.
    task automatic observe(input int n, input int inj_at, input logic [1:0] inj_sz);
        r_hit = '0; b_hit = '0; c_hit = '0; v_hit = '0; u_hit = '0;
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            r_hit[j] = result_ready;
            b_hit[j] = pipe0_blocked;
            c_hit[j] = chain_ready;
            v_hit[j] = lat_valid;
            u_hit[j] = mul_busy;
            lat_at[j] = int'(lat_cycles);
            issue_valid = (j == inj_at);
            if (j == inj_at) issue_size = inj_sz;
        end
        issue_valid = 1'b0;
    endtask

    task automatic quiet(input int n);
        issue_valid = 1'b0; p0_wr_valid = 1'b0; p1_wr_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic check_zero(input string req);
        chk(req, int'({mul_busy, pipe0_blocked, result_ready, chain_ready, lat_valid}), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_zero("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_zero("R1 after reset");

        // table walk
        foreach (VEC[k]) begin
            quiet(24);
            if (VEC[k].p2v) begin p1_wr_valid = 1'b1; p1_wr_reg = VEC[k].p2; end
            @(negedge clk);
            p1_wr_valid = 1'b0;
            if (VEC[k].p1v) begin p0_wr_valid = 1'b1; p0_wr_reg = VEC[k].p1; end
            @(negedge clk);
            p0_wr_valid = 1'b0;
            issue_size = VEC[k].sz; src_a = VEC[k].a; src_b = VEC[k].b;
            issue_valid = 1'b1;
            observe(24, 0, 2'd0);
            chk($sformatf("R9 R6 R7 latency vec%0d", k), v_hit[1] ? lat_at[1] : -1, int'(VEC[k].lat));
            chk($sformatf("R2 ready cycle vec%0d", k), first_set(r_hit), int'(VEC[k].lat));
            chk($sformatf("R11 ready count vec%0d", k), $countones(r_hit), 1);
            chk($sformatf("R8 chain cycle vec%0d", k), first_set(c_hit), int'(VEC[k].lat) + 1);
            chk($sformatf("R5 block cycle vec%0d", k), first_set(b_hit), exp_slot(VEC[k].sz));
            chk($sformatf("R5 block count vec%0d", k), $countones(b_hit), 1);
            chk($sformatf("R3 busy length vec%0d", k), $countones(u_hit), exp_occ(VEC[k].sz));
        end

        // R3: back-to-back 32-bit, second request in first free cycle
        quiet(24);
        src_a = 5'd20; src_b = 5'd21; issue_size = 2'd0; issue_valid = 1'b1;
        observe(24, 4, 2'd0);
        chk("R3 busy low at t+4", int'(u_hit[4]), 0);
        chk("R3 second accepted", int'(v_hit[5]), 1);
        chk("R3 busy cycles total", $countones(u_hit), 6);
        chk("R2 second ready at t+12", int'(r_hit[12]), 1);
        chk("R5 second block at t+9", int'(b_hit[9]), 1);

        // R4: request in last busy cycle of a 64-bit multiply is dropped
        quiet(24);
        issue_size = 2'd1; issue_valid = 1'b1;
        observe(24, 7, 2'd0);
        chk("R4 no lat_valid for dropped", $countones(v_hit), 1);
        chk("R4 single ready", $countones(r_hit), 1);
        chk("R4 single block", $countones(b_hit), 1);
        chk("R4 busy window unchanged", $countones(u_hit), 7);

        // R10: upper-half with near penalty (16) then 32-bit at t+8 (8) collide
        quiet(24);
        p0_wr_valid = 1'b1; p0_wr_reg = 5'd11;
        @(negedge clk);
        p0_wr_valid = 1'b0;
        issue_size = 2'd2; src_a = 5'd11; src_b = 5'd1; issue_valid = 1'b1;
        observe(24, 8, 2'd0);
        chk("R10 first latency", lat_at[1], 16);
        chk("R10 slipped latency", v_hit[9] ? lat_at[9] : -1, 9);
        chk("R10 ready at t+16", int'(r_hit[16]), 1);
        chk("R10 ready at t+17", int'(r_hit[17]), 1);
        chk("R11 two ready pulses", $countones(r_hit), 2);
        chk("R8 chain at t+18", int'(c_hit[18]), 1);

        // R1: reset in the middle of a multiply clears pending events
        quiet(24);
        issue_size = 2'd1; issue_valid = 1'b1;
        observe(3, 0, 2'd0);
        rst_n = 1'b0;
        @(negedge clk);
        check_zero("R1 reset mid-flight");
        rst_n = 1'b1;
        observe(24, 0, 2'd0);
        chk("R1 no stale ready", $countones(r_hit), 0);
        chk("R1 no stale block", $countones(b_hit), 0);
        chk("R1 no stale busy", $countones(u_hit), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule